// File: doc/BRIEF.md
# Register bank with access notification

This block is a small memory-mapped register bank that sits behind a simple single-cycle read/write bus. Software sees six 32-bit registers at 4-byte strides, grouped into three sections. The info section holds constants fixed at elaboration: a version word and a build identifier. The configuration section holds software-written values: a timeout wrap value and a scratch word. The status section holds values produced by the surrounding hardware: a live kernel value and an event counter.

Each register has an owner and its own read and write behaviour. Constant registers ignore writes. The timeout wrap register raises a one-cycle strobe toward internal logic whenever software writes it. The event counter is cleared by a bus read, and this clearing read never loses an increment that lands in the same cycle. Read data is registered and appears one cycle after the read enable.

Sections start at byte offsets 0x00 (info), 0x10 (configuration) and 0x20 (status). Each base is a parameter and must be a multiple of 16 bytes.

Top module: `regbank_notify`

## Requirements
- R1: After a synchronous active-low reset, `tmo_wrap` is 0x0000FFFF, `tmo_wr_stb` is 0, `rd_data` is 0, and both the scratch word and the event counter read back as 0.
- R2: `rd_data` carries the selected register's value in the cycle after the clock edge where `rd_en` was sampled high. It is 0 in the cycle after an edge where `rd_en` was low.
- R3: A read of byte offset 0x00 returns the version word, packed as bits 31:24 = MINOR_REV, bits 23:16 = MAJOR_REV and bits 15:0 = VENDOR_ID (default 0xDEAD).
- R4: The constant registers at 0x00 and 0x04 (0x04 returns BUILD_ID) ignore writes.
- R5: A write to 0x10 loads `wr_data` into the timeout wrap register. That register is readable at 0x10 and drives `tmo_wrap`, which changes only on such a write.
- R6: `tmo_wr_stb` is high for exactly the one cycle that follows each edge at which a write to 0x10 was sampled. It is low at all other times, including after writes to any other offset.
- R7: The scratch word at 0x14 is readable and writable, resets to 0, and raises no strobe.
- R8: A read of 0x20 returns `kern_val` as sampled at the read edge. Writes to 0x20 are ignored.
- R9: The event counter at 0x24 increments once for each cycle in which `perf_inc` is high. A read of 0x24 returns the count and clears the counter. Writes to 0x24 are ignored.
- R10: When a read of 0x24 and a high `perf_inc` fall in the same cycle, the read returns the old count and the counter restarts at 1.
- R11: Address bits 1:0 are ignored when decoding, for both reads and writes.
- R12: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | 32 | Registered read data |
| kern_val | input | 32 | Live value from internal logic |
| perf_inc | input | 1 | Event pulse that increments the counter |
| tmo_wrap | output | 32 | Current timeout wrap value |
| tmo_wr_stb | output | 1 | One-cycle pulse after a write to the timeout wrap register |

## Verification
A wrong stored value shows up only through a bus read or on `tmo_wrap`, so the bench reads every register and compares `rd_data` on the cycle after each read edge. The timeout value is exposed on every cycle and is compared continuously. A counter that skips or double-counts an event, or that clears at the wrong moment, first becomes visible at the next read of 0x24. For that reason, clearing reads are issued both with and without a coincident increment. A misrouted write shows up one cycle later as a stray strobe or a changed `tmo_wrap`, and otherwise at the next read of the register it corrupted.

// File: rtl/regbank_notify.sv
module regbank_notify #(
  parameter int          ADDR_W      = 8,
  parameter logic [15:0] VENDOR_ID   = 16'hDEAD,
  parameter logic [7:0]  MAJOR_REV   = 8'd1,
  parameter logic [7:0]  MINOR_REV   = 8'd0,
  parameter logic [31:0] BUILD_ID    = 32'h0000_0001,
  parameter logic [31:0] TMO_DEFAULT = 32'h0000_FFFF,
  parameter int          INFO_BASE   = 'h00,
  parameter int          CFG_BASE    = 'h10,
  parameter int          STAT_BASE   = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [31:0]       kern_val,
  input  logic              perf_inc,
  output logic [31:0]       tmo_wrap,
  output logic              tmo_wr_stb
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] W_VER   = WA'(INFO_BASE / 4);
  localparam logic [WA-1:0] W_BUILD = WA'(INFO_BASE / 4 + 1);
  localparam logic [WA-1:0] W_TMO   = WA'(CFG_BASE / 4);
  localparam logic [WA-1:0] W_SCR   = WA'(CFG_BASE / 4 + 1);
  localparam logic [WA-1:0] W_KVAL  = WA'(STAT_BASE / 4);
  localparam logic [WA-1:0] W_PERF  = WA'(STAT_BASE / 4 + 1);
  localparam logic [31:0]   VERSION = {MINOR_REV, MAJOR_REV, VENDOR_ID};

  logic [WA-1:0] word;
  logic [31:0]   tmo_q, scr_q, perf_q, rd_q, rd_mux;
  logic          stb_q;
  logic          unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  wire wr_tmo  = wr_en && (word == W_TMO);
  wire wr_scr  = wr_en && (word == W_SCR);
  wire rd_perf = rd_en && (word == W_PERF);

  always_comb begin
    case (word)
      W_VER:   rd_mux = VERSION;
      W_BUILD: rd_mux = BUILD_ID;
      W_TMO:   rd_mux = tmo_q;
      W_SCR:   rd_mux = scr_q;
      W_KVAL:  rd_mux = kern_val;
      W_PERF:  rd_mux = perf_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q  <= TMO_DEFAULT;
      scr_q  <= '0;
      perf_q <= '0;
      rd_q   <= '0;
      stb_q  <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q <= wr_data;
      if (wr_scr) scr_q <= wr_data;
      stb_q <= wr_tmo;
      rd_q  <= rd_en ? rd_mux : '0;
      if (rd_perf)       perf_q <= {31'b0, perf_inc};
      else if (perf_inc) perf_q <= perf_q + 32'd1;
    end
  end

  assign rd_data    = rd_q;
  assign tmo_wrap   = tmo_q;
  assign tmo_wr_stb = stb_q;
endmodule

// File: rtl/regbank_notify_chk.sv
module regbank_notify_chk #(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] VENDOR_ID = 16'hDEAD,
  parameter logic [7:0]  MAJOR_REV = 8'd1,
  parameter logic [7:0]  MINOR_REV = 8'd0,
  parameter int          INFO_BASE = 'h00,
  parameter int          CFG_BASE  = 'h10,
  parameter int          STAT_BASE = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic [31:0]       kern_val,
  input logic [31:0]       tmo_wrap,
  input logic              tmo_wr_stb
);
  localparam int WA = ADDR_W - 2;
  wire [WA-1:0] w = addr[ADDR_W-1:2];
  wire hit_tmo  = (w == WA'(CFG_BASE / 4));
  wire hit_ver  = (w == WA'(INFO_BASE / 4));
  wire hit_kval = (w == WA'(STAT_BASE / 4));
  wire mapped   = (w == WA'(INFO_BASE / 4)) || (w == WA'(INFO_BASE / 4 + 1)) ||
                  (w == WA'(CFG_BASE / 4))  || (w == WA'(CFG_BASE / 4 + 1))  ||
                  (w == WA'(STAT_BASE / 4)) || (w == WA'(STAT_BASE / 4 + 1));

  AST_TMO_STB_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_tmo) |=> tmo_wr_stb); // R6
  AST_TMO_STB_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_tmo) |=> !tmo_wr_stb); // R6
  AST_TMO_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_tmo) |=> (tmo_wrap == $past(wr_data))); // R5
  AST_TMO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_tmo) |=> $stable(tmo_wrap)); // R5
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == 32'd0)); // R2
  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_ver) |=> (rd_data == {MINOR_REV, MAJOR_REV, VENDOR_ID})); // R3
  AST_KVAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_kval) |=> (rd_data == $past(kern_val))); // R8
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rd_data == 32'd0)); // R12
endmodule

bind regbank_notify regbank_notify_chk #(
  .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .MAJOR_REV(MAJOR_REV), .MINOR_REV(MINOR_REV),
  .INFO_BASE(INFO_BASE), .CFG_BASE(CFG_BASE), .STAT_BASE(STAT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .kern_val(kern_val), .tmo_wrap(tmo_wrap),
  .tmo_wr_stb(tmo_wr_stb)
);

// File: tb/tb_regbank_notify.sv
`timescale 1ns/1ps
module tb_regbank_notify;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr_en = 0, rd_en = 0, perf_inc = 0;
  logic [31:0] wr_data = 0, kern_val = 32'h1234_5678;
  logic [31:0] rd_data, tmo_wrap;
  logic        tmo_wr_stb;

  int checks = 0, fails = 0;
  bit ready = 0;
  string tag = "R1";

  localparam logic [31:0] EXP_VER   = 32'h0703_DEAD;
  localparam logic [31:0] EXP_BUILD = 32'hC0DE_0042;

  always #2 clk = ~clk;

  regbank_notify #(.MAJOR_REV(8'h03), .MINOR_REV(8'h07), .BUILD_ID(EXP_BUILD)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .kern_val(kern_val), .perf_inc(perf_inc),
    .tmo_wrap(tmo_wrap), .tmo_wr_stb(tmo_wr_stb));

  // reference model
  logic [31:0] m_tmo, m_scr, m_perf, m_rd;
  logic        m_stb;

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a & 8'hFC)
      8'h00: return EXP_VER;
      8'h04: return EXP_BUILD;
      8'h10: return m_tmo;
      8'h14: return m_scr;
      8'h20: return kern_val;
      8'h24: return m_perf;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmo = 32'h0000_FFFF; m_scr = 0; m_perf = 0; m_rd = 0; m_stb = 0;
    end else begin
      logic [31:0] r;
      r = rd_en ? mread(addr) : 32'd0;
      if (rd_en && (addr & 8'hFC) == 8'h24) m_perf = perf_inc ? 32'd1 : 32'd0;
      else if (perf_inc) m_perf = m_perf + 1;
      m_stb = wr_en && (addr & 8'hFC) == 8'h10;
      if (wr_en && (addr & 8'hFC) == 8'h10) m_tmo = wr_data;
      if (wr_en && (addr & 8'hFC) == 8'h14) m_scr = wr_data;
      m_rd = r;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (ready) begin
    chk(rd_data == m_rd, tag, rd_data, m_rd);
    chk(tmo_wrap == m_tmo, "R5", tmo_wrap, m_tmo);
    chk(tmo_wr_stb == m_stb, "R6", {31'b0, tmo_wr_stb}, {31'b0, m_stb});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ready = 1;
    // R1 reset state
    chk(tmo_wrap == 32'h0000_FFFF, "R1", tmo_wrap, 32'h0000_FFFF);
    chk(tmo_wr_stb == 0, "R1", {31'b0, tmo_wr_stb}, 0);
    chk(rd_data == 0, "R1", rd_data, 0);
    rd(8'h14, 0, "R1");
    rd(8'h24, 0, "R1");
    // R2 idle read data
    @(negedge clk);
    chk(rd_data == 0, "R2", rd_data, 0);
    // R3 / R4 constants
    tag = "R3"; rd(8'h00, EXP_VER, "R3");
    tag = "R4"; wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h0);
    rd(8'h00, EXP_VER, "R4"); rd(8'h04, EXP_BUILD, "R4");
    // R5 / R6 timeout wrap and strobe
    tag = "R5"; wr(8'h10, 32'hA5A5_0001);
    chk(tmo_wr_stb == 1, "R6", {31'b0, tmo_wr_stb}, 1);
    chk(tmo_wrap == 32'hA5A5_0001, "R5", tmo_wrap, 32'hA5A5_0001);
    @(negedge clk);
    chk(tmo_wr_stb == 0, "R6", {31'b0, tmo_wr_stb}, 0);
    rd(8'h10, 32'hA5A5_0001, "R5");
    // R7 scratch
    tag = "R7"; wr(8'h14, 32'h0BAD_F00D);
    chk(tmo_wr_stb == 0, "R7", {31'b0, tmo_wr_stb}, 0);
    rd(8'h14, 32'h0BAD_F00D, "R7");
    // R8 kernel value
    tag = "R8"; kern_val = 32'hCAFE_0123; wr(8'h20, 32'h0);
    rd(8'h20, 32'hCAFE_0123, "R8");
    // R9 counter
    tag = "R9";
    repeat (5) begin perf_inc = 1; @(negedge clk); end
    perf_inc = 0;
    rd(8'h24, 5, "R9");
    rd(8'h24, 0, "R9");
    wr(8'h24, 32'h77);
    rd(8'h24, 0, "R9");
    // R10 coincident clear and increment
    tag = "R10";
    repeat (3) begin perf_inc = 1; @(negedge clk); end
    addr = 8'h24; rd_en = 1; perf_inc = 1;
    @(negedge clk);
    rd_en = 0; perf_inc = 0;
    chk(rd_data == 3, "R10", rd_data, 3);
    rd(8'h24, 1, "R10");
    // R11 low address bits ignored
    tag = "R11"; wr(8'h13, 32'h0000_1234);
    chk(tmo_wrap == 32'h0000_1234, "R11", tmo_wrap, 32'h0000_1234);
    rd(8'h02, EXP_VER, "R11"); rd(8'h17, 32'h0BAD_F00D, "R11");
    // R12 unmapped
    tag = "R12"; wr(8'h30, 32'hDEAD_BEEF); wr(8'hFC, 32'h1);
    chk(tmo_wr_stb == 0, "R12", {31'b0, tmo_wr_stb}, 0);
    rd(8'h30, 0, "R12"); rd(8'h18, 0, "R12");
    rd(8'h10, 32'h0000_1234, "R12"); rd(8'h14, 32'h0BAD_F00D, "R12");
    // mixed traffic against the model
    tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] pick [8] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h20, 8'h24, 8'h30, 8'hFC};
      addr     = pick[$urandom_range(7)] | 8'($urandom_range(3));
      wr_en    = ($urandom_range(3) == 0);
      rd_en    = ($urandom_range(1) == 0);
      perf_inc = ($urandom_range(2) == 0);
      wr_data  = $urandom;
      kern_val = $urandom;
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; perf_inc = 0;
    @(negedge clk);
    finish_run();
  end
endmodule